// File: doc/BRIEF.md
# Master-partitioned read prefetch buffer

This block sits between a multi-master read port and a slow external memory that returns 64-bit beats. A 1 KB pool (128 beats of 8 bytes) is split into four slots. Slots 0 to 2 each have a master-ID field, a size field counted in beats, and a prefetch-enable bit. Slot 3 is the catch-all. It ignores its own ID and size fields, and it owns whatever part of the pool the first three slots leave free. Each request is steered to a slot by the requesting master's ID. Each slot tracks one contiguous run of beats, given by a base beat address and a count of valid beats.

A request is held on the read port until the block answers it with a one-cycle valid pulse carrying a 32-bit word. If the addressed beat is held in the master's slot, the answer comes one cycle after the request is sampled, and the memory is not touched. Otherwise the slot restarts at the missed beat and the memory is asked for that beat. With prefetch on, the block keeps fetching the following sequential beats until the slot is full. Only one memory request is ever in flight. Any change to the configuration inputs invalidates every slot.

Top module: `prf_buf`

## Requirements
- R1: Sizes of slots 0..2 are taken in beat units and clipped in slot order against the 128 beats still free. Slot 3 receives the remaining beats, so the effective sizes always add up to 128.
- R2: A request uses the lowest-numbered slot among 0..2 whose effective size is non-zero and whose master-ID field equals the request's ID. Every other request uses slot 3. The ID and size fields of slot 3 have no effect.
- R3: A hit raises rd_valid_o exactly one cycle after the request is sampled, and no memory request is issued. Byte address bit 2 chooses the word: 0 gives beat bits 31:0, 1 gives bits 63:32.
- R4: On a miss, the slot's base becomes the missed beat (byte address shifted right by 3). The memory is asked for that beat first, and the request is answered with the word taken from it.
- R5: With the slot's prefetch bit set, a miss fetches consecutive beats until the slot holds its full effective size. With the bit clear, only the missed beat is fetched.
- R6: Slots fill independently, so accesses from one master never remove data held in another master's slot.
- R7: Any change on cfg_mid_i, cfg_size_i or cfg_pf_i empties all slots, and the next access to any previously held beat misses.
- R8: A slot whose effective size is 0 never hits and stores nothing. Each access to it fetches exactly one beat.
- R9: mem_req_o is a single-cycle pulse, and no new one is issued before mem_rvalid_i has returned the previous beat.
- R10: When slots 0..2 all have size 0, slot 3 serves every master ID using all 128 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mid_i | input | 16 | Master ID per slot, 4 bits each, slot 0 in the low bits |
| cfg_size_i | input | 32 | Size per slot in beats, 8 bits each |
| cfg_pf_i | input | 4 | Prefetch enable per slot |
| rd_req_i | input | 1 | Read request, held until rd_valid_o |
| rd_mid_i | input | 4 | Master ID of the request |
| rd_addr_i | input | 32 | Byte address of the request |
| rd_valid_o | output | 1 | One-cycle response pulse |
| rd_data_o | output | 32 | Response word |
| mem_req_o | output | 1 | Memory beat request pulse |
| mem_addr_o | output | 29 | Beat address of the memory request |
| mem_rvalid_i | input | 1 | Memory beat return strobe |
| mem_rdata_i | input | 64 | Returned beat |

## Verification
On every cycle the assertions check the following. There is at most one memory request in flight. The request strobe is a pulse. Each response follows a request. The effective sizes always cover the whole pool. No slot holds more beats than its effective size. One cycle after any configuration change, every slot is empty. The bench's scenarios are the only way to show that the right slot is chosen and that hits return the right word. They also show how many beats prefetch fetches under clipped sizes, that interleaved masters keep their own contents, and that a zero-size slot is bypassed every time.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int POOL_BYTES = 1024;
  localparam int BEAT_BYTES = 8;
  localparam int NSLOT      = 4;
  localparam int POOL_BEATS = POOL_BYTES / BEAT_BYTES;
  localparam int CW         = $clog2(POOL_BEATS + 1);
  localparam int IW         = $clog2(POOL_BEATS);
  localparam int SW         = $clog2(NSLOT);
  localparam int BEAT_SH    = $clog2(BEAT_BYTES);
  localparam int MDW        = 8 * BEAT_BYTES;
  localparam int RDW        = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_MWAIT} st_e;
endpackage

// File: rtl/prf_slot_map.sv
module prf_slot_map import prf_pkg::*; #(
  parameter int MID_W = 4
) (
  input  logic [NSLOT-1:0][MID_W-1:0] cfg_mid_i,
  input  logic [NSLOT-1:0][CW-1:0]    cfg_size_i,
  input  logic [MID_W-1:0]            rd_mid_i,
  output logic [NSLOT-1:0][CW-1:0]    eff_o,
  output logic [NSLOT-1:0][CW-1:0]    off_o,
  output logic [SW-1:0]               sel_o
);
  logic [CW-1:0] left;
  logic          found;

  always_comb begin
    left = CW'(POOL_BEATS);
    for (int i = 0; i < NSLOT - 1; i++) begin
      off_o[i] = CW'(POOL_BEATS) - left;
      eff_o[i] = (cfg_size_i[i] > left) ? left : cfg_size_i[i];
      left     = left - eff_o[i];
    end
    // last slot: remainder, own size field ignored
    off_o[NSLOT-1] = CW'(POOL_BEATS) - left;
    eff_o[NSLOT-1] = left;
  end

  always_comb begin
    sel_o = SW'(NSLOT - 1);
    found = 1'b0;
    for (int i = 0; i < NSLOT - 1; i++) begin
      if (!found && eff_o[i] != '0 && cfg_mid_i[i] == rd_mid_i) begin
        sel_o = SW'(i);
        found = 1'b1;
      end
    end
  end

  logic unused_mid;
  assign unused_mid = ^cfg_mid_i[NSLOT-1];
endmodule

// File: rtl/prf_pool.sv
module prf_pool import prf_pkg::*; (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [IW-1:0]  waddr_i,
  input  logic [MDW-1:0] wdata_i,
  input  logic [IW-1:0]  raddr_i,
  output logic [MDW-1:0] rdata_o
);
  logic [MDW-1:0] mem_q [POOL_BEATS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/prf_buf.sv
module prf_buf import prf_pkg::*; #(
  parameter int MID_W = 4,
  parameter int AW    = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSLOT*MID_W-1:0] cfg_mid_i,
  input  logic [NSLOT*CW-1:0]    cfg_size_i,
  input  logic [NSLOT-1:0]       cfg_pf_i,
  input  logic                   rd_req_i,
  input  logic [MID_W-1:0]       rd_mid_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic                   rd_valid_o,
  output logic [RDW-1:0]         rd_data_o,
  output logic                   mem_req_o,
  output logic [AW-BEAT_SH-1:0]  mem_addr_o,
  input  logic                   mem_rvalid_i,
  input  logic [MDW-1:0]         mem_rdata_i
);
  localparam int BW   = AW - BEAT_SH;
  localparam int CFGW = NSLOT * (MID_W + CW + 1);

  logic [NSLOT-1:0][MID_W-1:0] mid_cfg;
  logic [NSLOT-1:0][CW-1:0]    size_cfg;
  logic [NSLOT-1:0][CW-1:0]    eff_size, off;
  logic [SW-1:0]               sel;

  assign mid_cfg  = cfg_mid_i;
  assign size_cfg = cfg_size_i;

  prf_slot_map #(.MID_W(MID_W)) u_map (
    .cfg_mid_i (mid_cfg),
    .cfg_size_i(size_cfg),
    .rd_mid_i  (rd_mid_i),
    .eff_o     (eff_size),
    .off_o     (off),
    .sel_o     (sel)
  );

  st_e                         state_q;
  logic [NSLOT-1:0][BW-1:0]    base_q;
  logic [NSLOT-1:0][CW-1:0]    cnt_q;
  logic [SW-1:0]               sel_q;
  logic [BW-1:0]               fetch_q;
  logic                        pend_q, word_q, fill_ok_q;
  logic                        rd_valid_q;
  logic [RDW-1:0]              rd_data_q;
  logic [CFGW-1:0]             cfg_q;

  logic [CFGW-1:0] cfg_now;
  logic            cfg_chg;
  assign cfg_now = {cfg_mid_i, cfg_size_i, cfg_pf_i};
  assign cfg_chg = cfg_now != cfg_q;

  // lookup
  logic [BW-1:0]  beat, rel;
  logic           hit;
  logic [CW-1:0]  ridx, widx, nxt;
  logic [MDW-1:0] rbeat;
  logic [RDW-1:0] rword;
  logic           we, cont;

  assign beat  = rd_addr_i[AW-1:BEAT_SH];
  assign rel   = beat - base_q[sel];
  assign hit   = (cnt_q[sel] != '0) && (rel < BW'(cnt_q[sel]));
  assign ridx  = off[sel] + rel[CW-1:0];
  assign widx  = off[sel_q] + cnt_q[sel_q];
  assign rword = rd_addr_i[BEAT_SH-1] ? rbeat[MDW-1:RDW] : rbeat[RDW-1:0];
  assign we    = (state_q == ST_MWAIT) && mem_rvalid_i && fill_ok_q;
  assign nxt   = cnt_q[sel_q] + CW'(1);
  assign cont  = fill_ok_q && cfg_pf_i[sel_q] && !cfg_chg && (nxt < eff_size[sel_q]);

  prf_pool u_pool (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(widx[IW-1:0]),
    .wdata_i(mem_rdata_i),
    .raddr_i(ridx[IW-1:0]),
    .rdata_o(rbeat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      cnt_q      <= '0;
      sel_q      <= '0;
      fetch_q    <= '0;
      pend_q     <= 1'b0;
      word_q     <= 1'b0;
      fill_ok_q  <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      cfg_q      <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rd_req_i && !cfg_chg) begin
            if (hit) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= rword;
            end else begin
              sel_q     <= sel;
              fetch_q   <= beat;
              word_q    <= rd_addr_i[BEAT_SH-1];
              pend_q    <= 1'b1;
              fill_ok_q <= eff_size[sel] != '0;
              if (eff_size[sel] != '0) begin
                base_q[sel] <= beat;
                cnt_q[sel]  <= '0;
              end
              state_q <= ST_MREQ;
            end
          end
        end
        ST_MREQ: state_q <= ST_MWAIT;
        ST_MWAIT: begin
          if (mem_rvalid_i) begin
            if (fill_ok_q) cnt_q[sel_q] <= nxt;
            if (pend_q) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= word_q ? mem_rdata_i[MDW-1:RDW] : mem_rdata_i[RDW-1:0];
              pend_q     <= 1'b0;
            end
            if (cont) begin
              fetch_q <= fetch_q + BW'(1);
              state_q <= ST_MREQ;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      // config change wins over any fill update
      if (cfg_chg) begin
        cfg_q     <= cfg_now;
        cnt_q     <= '0;
        fill_ok_q <= 1'b0;
      end
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign mem_req_o  = state_q == ST_MREQ;
  assign mem_addr_o = fetch_q;

  logic unused_bits;
  assign unused_bits = ^{rd_addr_i[BEAT_SH-2:0], ridx[CW-1:IW], widx[CW-1:IW]};
endmodule

// File: rtl/prf_buf_chk.sv
module prf_buf_chk import prf_pkg::*; #(
  parameter int CFGW = 52
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [CFGW-1:0]      cfg_i,
  input logic                 rd_req_i,
  input logic                 rd_valid_o,
  input logic                 mem_req_o,
  input logic                 mem_rvalid_i,
  input logic [NSLOT*CW-1:0]  cnt_i,
  input logic [NSLOT*CW-1:0]  eff_i
);
  logic out_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           out_q <= 1'b0;
    else if (mem_req_o)    out_q <= 1'b1;
    else if (mem_rvalid_i) out_q <= 1'b0;
  end

  logic [CW+SW-1:0] eff_sum;
  always_comb begin
    eff_sum = '0;
    for (int i = 0; i < NSLOT; i++) eff_sum = eff_sum + (CW+SW)'(eff_i[i*CW +: CW]);
  end

  a_r9_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !out_q);
  a_r9_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r3_resp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i));
  a_r7_cfg_invalidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i != $past(cfg_i)) |=> (cnt_i == '0));
  a_r1_pool_covered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_sum == (CW+SW)'(POOL_BEATS));

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    a_r1_cnt_in_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i == $past(cfg_i)) |-> (cnt_i[g*CW +: CW] <= eff_i[g*CW +: CW]));
  end
endmodule

bind prf_buf prf_buf_chk #(.CFGW(CFGW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_i       ({cfg_mid_i, cfg_size_i, cfg_pf_i}),
  .rd_req_i    (rd_req_i),
  .rd_valid_o  (rd_valid_o),
  .mem_req_o   (mem_req_o),
  .mem_rvalid_i(mem_rvalid_i),
  .cnt_i       (cnt_q),
  .eff_i       (eff_size)
);

// File: tb/tb_prf_buf.sv
module tb_prf_buf;
  localparam int MID_W = 4;
  localparam int AW    = 32;
  localparam int NS    = 4;
  localparam int BEATS = 128;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic [NS-1:0][MID_W-1:0] cmid = '0;
  logic [NS-1:0][7:0]       csize = '0;
  logic [NS-1:0]            cpf = '0;
  logic              rd_req_i = 1'b0;
  logic [MID_W-1:0]  rd_mid_i = '0;
  logic [AW-1:0]     rd_addr_i = '0;
  logic              rd_valid_o;
  logic [31:0]       rd_data_o;
  logic              mem_req_o;
  logic [AW-4:0]     mem_addr_o;
  logic              mem_rvalid_i = 1'b0;
  logic [63:0]       mem_rdata_i = '0;

  prf_buf #(.MID_W(MID_W), .AW(AW)) dut (
    .clk_i, .rst_ni,
    .cfg_mid_i(cmid), .cfg_size_i(csize), .cfg_pf_i(cpf),
    .rd_req_i, .rd_mid_i, .rd_addr_i, .rd_valid_o, .rd_data_o,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i
  );

  int checks = 0, errors = 0, overlap = 0, mreq_cnt = 0, lat = 0;
  logic [AW-4:0] paddr;
  bit done = 0;

  function automatic logic [63:0] memfn(input logic [28:0] b);
    return {3'b101, b, 3'b011, b ^ 29'h0ABCDEF};
  endfunction

  // memory model: 2-cycle latency, single beat per request
  always @(negedge clk_i) begin
    mem_rvalid_i = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = memfn(paddr);
      end
    end
    if (mem_req_o) begin
      mreq_cnt++;
      if (lat != 0 || mem_rvalid_i) overlap++;
      paddr = mem_addr_o;
      lat = 2;
    end
  end

  // reference state
  int mbase[NS], mcnt[NS];

  function automatic int eff(input int s);
    int left = BEATS;
    int e;
    for (int i = 0; i < NS - 1; i++) begin
      e = (int'(csize[i]) > left) ? left : int'(csize[i]);
      if (i == s) return e;
      left -= e;
    end
    return left;
  endfunction

  function automatic int pick(input logic [MID_W-1:0] m);
    for (int i = 0; i < NS - 1; i++)
      if (eff(i) > 0 && cmid[i] == m) return i;
    return NS - 1;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic rd(input logic [MID_W-1:0] m, input logic [AW-1:0] a, input string rq);
    int s = pick(m);
    int b = int'(a >> 3);
    bit h = mcnt[s] > 0 && b >= mbase[s] && b < mbase[s] + mcnt[s];
    logic [63:0] bt = memfn(29'(b));
    logic [31:0] exp = a[2] ? bt[63:32] : bt[31:0];
    int nf = (eff(s) == 0) ? 1 : (cpf[s] ? eff(s) : 1);
    int cyc = 0, quiet = 0;
    logic [31:0] got;
    @(negedge clk_i);
    mreq_cnt = 0;
    rd_req_i = 1'b1; rd_mid_i = m; rd_addr_i = a;
    do begin
      @(posedge clk_i); #1; cyc++;
    end while (!rd_valid_o && cyc < 2000);
    got = rd_data_o;
    @(negedge clk_i);
    rd_req_i = 1'b0;
    while (quiet < 6) begin
      @(posedge clk_i); #1;
      if (mem_req_o || lat != 0) quiet = 0; else quiet++;
    end
    chk(got == exp, rq, "data", got, exp);
    if (h) begin
      chk(cyc == 1, rq, "hit latency", cyc, 1);
      chk(mreq_cnt == 0, rq, "hit mem requests", mreq_cnt, 0);
    end else begin
      chk(mreq_cnt == nf, rq, "miss fetch count", mreq_cnt, nf);
      if (eff(s) > 0) begin mbase[s] = b; mcnt[s] = nf; end
    end
  endtask

  task automatic setcfg(input logic [NS-1:0][MID_W-1:0] m, input logic [NS-1:0][7:0] sz,
                        input logic [NS-1:0] pf);
    @(negedge clk_i);
    cmid = m; csize = sz; cpf = pf;
    repeat (2) @(posedge clk_i);
    for (int i = 0; i < NS; i++) mcnt[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin mbase[i] = 0; mcnt[i] = 0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(rd_valid_o == 0, "R9", "reset rd_valid", rd_valid_o, 0);
    chk(mem_req_o == 0, "R9", "reset mem_req", mem_req_o, 0);

    // R10/R2: all sized-slot fields zero, slot 3 fields nonsense
    setcfg({4'd9, 4'd2, 4'd1, 4'd0}, {8'd5, 8'd0, 8'd0, 8'd0}, 4'b1000);
    rd(4'd0, 32'h0000_0100, "R10");
    rd(4'd5, 32'h0000_0100 + 32'd8 * 32'd100 + 32'd4, "R10");
    rd(4'd3, 32'h0000_0100 + 32'd8 * 32'd127, "R2");
    rd(4'd3, 32'h0000_0100 + 32'd8 * 32'd128, "R10");

    // split pool
    setcfg({4'd7, 4'd2, 4'd1, 4'd0}, {8'd200, 8'd0, 8'd2, 8'd4}, 4'b0001);
    rd(4'd0, 32'h0000_1000, "R5");
    rd(4'd1, 32'h0000_2000, "R4");
    rd(4'd0, 32'h0000_1018, "R6");
    rd(4'd1, 32'h0000_2004, "R3");
    rd(4'd1, 32'h0000_2008, "R4");
    rd(4'd0, 32'h0000_1000, "R6");
    rd(4'd2, 32'h0000_3000, "R2");
    rd(4'd2, 32'h0000_3000, "R3");
    rd(4'd7, 32'h0000_3004, "R2");

    // R7: toggle only slot 3 prefetch bit
    setcfg({4'd7, 4'd2, 4'd1, 4'd0}, {8'd200, 8'd0, 8'd2, 8'd4}, 4'b1001);
    rd(4'd0, 32'h0000_1000, "R7");
    rd(4'd2, 32'h0000_3000, "R7");

    // R1/R8: clipping leaves slot 1 and slot 3 empty
    setcfg({4'd0, 4'd2, 4'd1, 4'd0}, {8'd9, 8'd0, 8'd50, 8'd200}, 4'b1111);
    rd(4'd1, 32'h0000_4000, "R8");
    rd(4'd1, 32'h0000_4000, "R8");
    rd(4'd0, 32'h0000_8000, "R1");
    rd(4'd0, 32'h0000_8000 + 32'd8 * 32'd127 + 32'd4, "R1");
    rd(4'd0, 32'h0000_8000 + 32'd8 * 32'd128, "R1");

    // R1: partial clip, slot 1 keeps 28 beats
    setcfg({4'd0, 4'd2, 4'd1, 4'd0}, {8'd0, 8'd0, 8'd50, 8'd100}, 4'b0010);
    rd(4'd1, 32'h0001_0000, "R1");
    rd(4'd1, 32'h0001_0000 + 32'd8 * 32'd27, "R1");
    rd(4'd1, 32'h0001_0000 + 32'd8 * 32'd28, "R1");

    chk(overlap == 0, "R9", "overlapping memory requests", overlap, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule